// File: doc/BRIEF.md
# Floating-Point Move and Sign Unit

This block carries out the floating-point register operations that do no arithmetic. It handles plain moves and conditional moves, which copy a bit pattern unchanged. It also handles absolute value and negate, which touch only the sign bit. Each operation works on a 32-bit single operand or a 64-bit double operand.

A conditional move is gated in one of two ways. The first is one bit picked from an eight-bit floating-point condition-code vector. The second is a test of whether an integer operand is zero. When the gate fails, the unit signals that the destination must not be written. The sign operations raise an invalid flag when the operand is a signalling NaN, and they still deliver the sign-adjusted pattern.

The datapath itself is combinational. Its result, write enable and invalid flag are registered, so every accepted request produces exactly one result one clock later. The register file that consumes the result stays outside the block.

Top module: `fpm_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it, `res_o`, `wr_en_o`, `inv_o` and `valid_o` are all zero.
- R2: A request taken with `valid_i` high produces `valid_o` high on the next clock edge only. Without a request, `valid_o` is low.
- R3: Opcode 0 (plain move) returns the source unchanged with `wr_en_o` high and `inv_o` low, even when the source is a signalling NaN.
- R4: Opcode 1 writes when `cc_i[cc_sel_i]` is 1. Opcode 2 writes when that bit is 0. `cc_sel_i` is a 3-bit index into the eight condition bits.
- R5: Opcode 3 writes when every bit of `iop_i` is zero. Opcode 4 writes when any bit of `iop_i` is set. The test spans the full integer width whatever the format.
- R6: When `wr_en_o` is low with `valid_o` high, `res_o` is zero and `inv_o` is low.
- R7: Opcode 5 (absolute value) clears the sign bit and opcode 6 (negate) inverts it. The sign bit is bit 63 for double and bit 31 for single. All other result bits equal the source.
- R8: Opcodes 5 and 6 set `inv_o` exactly when the operand is a signalling NaN: exponent all ones, fraction nonzero, and fraction MSB 0. Quiet NaNs, infinities and numbers never set it. No other opcode sets it.
- R9: With `fmt_i` = 0 (single), bits 63:32 of the source are ignored, including for the NaN test, and bits 63:32 of `res_o` are zero. `fmt_i` = 1 selects double.
- R10: Opcode 7 is reserved. It yields `wr_en_o` low, `inv_o` low and `res_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present |
| op_i | input | 3 | Operation code (see R3 to R10) |
| fmt_i | input | 1 | 0 single, 1 double |
| src_i | input | 64 | Source operand bit pattern |
| cc_i | input | 8 | Floating-point condition-code bits |
| cc_sel_i | input | 3 | Index of the condition bit tested |
| iop_i | input | 64 | Integer operand for the zero test |
| valid_o | output | 1 | Result present |
| res_o | output | 64 | Result bit pattern |
| wr_en_o | output | 1 | Destination must be written |
| inv_o | output | 1 | Invalid-operation flag |

## Verification
Several properties are checked on every cycle by the assertions:
- the one-cycle latency;
- the quiet outputs when no write happens;
- the zeroed upper half in single format;
- the exact copy of a double move;
- the sign-bit-only change of a double absolute value;
- the rule that only sign operations can flag invalid.

Other behaviour needs the bench's chosen operands to be shown. This covers the exact NaN classification boundaries: quiet NaN, infinity, and a NaN present only in the ignored upper half. It also covers the full-width integer zero test with a lone top bit set, the condition bit picked at the extreme indices, and single-format negate results.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    OP_MOV  = 3'd0,
    OP_MOVT = 3'd1,
    OP_MOVF = 3'd2,
    OP_MOVZ = 3'd3,
    OP_MOVN = 3'd4,
    OP_ABS  = 3'd5,
    OP_NEG  = 3'd6,
    OP_RSVD = 3'd7
  } fpm_op_e;

  typedef enum logic {
    FMT_S = 1'b0,
    FMT_D = 1'b1
  } fpm_fmt_e;

  function automatic logic is_sign_op(fpm_op_e op);
    return (op == OP_ABS) || (op == OP_NEG);
  endfunction

endpackage

// File: rtl/fpm_snan.sv
module fpm_snan #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  output logic         snan_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f  = val_i[W-2 -: EXP_W];
    frac_f = val_i[FRAC_W-1:0];
    // quiet bit clear, payload present, exponent saturated
    snan_o = (&exp_f) && (|frac_f) && !frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fpm_cond.sv
module fpm_cond
  import fpm_pkg::*;
#(
  parameter int CCW   = 8,
  parameter int IW    = 64,
  localparam int SELW = (CCW > 1) ? $clog2(CCW) : 1
) (
  input  fpm_op_e         op_i,
  input  logic [CCW-1:0]  cc_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [IW-1:0]   iop_i,
  output logic            take_o
);
  logic cc_bit;
  logic int_zero;

  always_comb begin
    cc_bit   = cc_i[sel_i];
    int_zero = (iop_i == '0);
    unique case (op_i)
      OP_MOV, OP_ABS, OP_NEG: take_o = 1'b1;
      OP_MOVT:                take_o = cc_bit;
      OP_MOVF:                take_o = !cc_bit;
      OP_MOVZ:                take_o = int_zero;
      OP_MOVN:                take_o = !int_zero;
      default:                take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpm_sign.sv
module fpm_sign
  import fpm_pkg::*;
#(
  parameter int W = 64
) (
  input  fpm_op_e      op_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    res_o = val_i;
    if (op_i == OP_ABS)      res_o[W-1] = 1'b0;
    else if (op_i == OP_NEG) res_o[W-1] = ~val_i[W-1];
  end
endmodule

// File: rtl/fpm_unit.sv
module fpm_unit
  import fpm_pkg::*;
#(
  parameter int DW    = 64,
  parameter int SW    = 32,
  parameter int D_EXP = 11,
  parameter int S_EXP = 8,
  parameter int CCW   = 8,
  parameter int IW    = 64,
  localparam int D_FRAC = DW - 1 - D_EXP,
  localparam int S_FRAC = SW - 1 - S_EXP,
  localparam int SELW   = (CCW > 1) ? $clog2(CCW) : 1,
  localparam int NFMT   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic            fmt_i,
  input  logic [DW-1:0]   src_i,
  input  logic [CCW-1:0]  cc_i,
  input  logic [SELW-1:0] cc_sel_i,
  input  logic [IW-1:0]   iop_i,
  output logic            valid_o,
  output logic [DW-1:0]   res_o,
  output logic            wr_en_o,
  output logic            inv_o
);
  fpm_op_e  op;
  fpm_fmt_e fmt;
  logic     take;
  logic [NFMT-1:0] snan_v;
  logic [DW-1:0]   fres [NFMT];
  logic [DW-1:0]   nxt_res;
  logic            nxt_inv;

  assign op  = fpm_op_e'(op_i);
  assign fmt = fpm_fmt_e'(fmt_i);

  fpm_cond #(.CCW(CCW), .IW(IW)) u_cond (
    .op_i  (op),
    .cc_i  (cc_i),
    .sel_i (cc_sel_i),
    .iop_i (iop_i),
    .take_o(take)
  );

  // one lane per format: index 0 single, index 1 double
  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int LW = (g == 0) ? SW : DW;
    localparam int LE = (g == 0) ? S_EXP : D_EXP;
    localparam int LF = (g == 0) ? S_FRAC : D_FRAC;
    logic [LW-1:0] lane_res;

    fpm_snan #(.EXP_W(LE), .FRAC_W(LF)) u_snan (
      .val_i (src_i[LW-1:0]),
      .snan_o(snan_v[g])
    );

    fpm_sign #(.W(LW)) u_sign (
      .op_i (op),
      .val_i(src_i[LW-1:0]),
      .res_o(lane_res)
    );

    if (LW == DW) begin : g_full
      assign fres[g] = lane_res;
    end else begin : g_pad
      assign fres[g] = {{(DW-LW){1'b0}}, lane_res};
    end
  end

  always_comb begin
    nxt_res = take ? fres[fmt] : '0;
    nxt_inv = take && is_sign_op(op) && snan_v[fmt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      wr_en_o <= 1'b0;
      inv_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      res_o   <= valid_i ? nxt_res : '0;
      wr_en_o <= valid_i && take;
      inv_o   <= valid_i && nxt_inv;
    end
  end
endmodule

// File: rtl/fpm_unit_chk.sv
module fpm_unit_chk #(
  parameter int DW   = 64,
  parameter int SW   = 32,
  parameter int CCW  = 8,
  parameter int IW   = 64,
  localparam int SELW = (CCW > 1) ? $clog2(CCW) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_i,
  input logic [2:0]      op_i,
  input logic            fmt_i,
  input logic [DW-1:0]   src_i,
  input logic [CCW-1:0]  cc_i,
  input logic [SELW-1:0] cc_sel_i,
  input logic [IW-1:0]   iop_i,
  input logic            valid_o,
  input logic [DW-1:0]   res_o,
  input logic            wr_en_o,
  input logic            inv_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && !wr_en_o && !inv_o && res_o == '0));

  p_lat_on_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  p_lat_off_r2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && !wr_en_o && !inv_o));

  p_mov_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd0 && fmt_i) |=>
      (res_o == $past(src_i) && wr_en_o && !inv_o));

  p_movt_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd1 && cc_i[cc_sel_i]) |=> wr_en_o);
  p_movf_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd2 && cc_i[cc_sel_i]) |=> !wr_en_o);

  p_movz_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd3 && iop_i == '0) |=> wr_en_o);
  p_movn_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd4 && iop_i == '0) |=> !wr_en_o);

  p_fail_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !wr_en_o) |-> (res_o == '0 && !inv_o));

  p_abs_dbl_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd5 && fmt_i) |=>
      (!res_o[DW-1] && res_o[DW-2:0] == $past(src_i[DW-2:0])));

  p_inv_src_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i != 3'd5 && op_i != 3'd6) |=> !inv_o);

  p_single_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !fmt_i) |=> (res_o[DW-1:SW] == '0));

  p_rsvd_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'd7) |=> (!wr_en_o && res_o == '0));
endmodule

bind fpm_unit fpm_unit_chk #(.DW(DW), .SW(SW), .CCW(CCW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .fmt_i(fmt_i),
  .src_i(src_i), .cc_i(cc_i), .cc_sel_i(cc_sel_i), .iop_i(iop_i),
  .valid_o(valid_o), .res_o(res_o), .wr_en_o(wr_en_o), .inv_o(inv_o)
);

// File: tb/sim_fpm_unit.sv
`timescale 1ns/1ps
module sim_fpm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        fmt_i = 1'b0;
  logic [63:0] src_i = '0;
  logic [7:0]  cc_i = '0;
  logic [2:0]  cc_sel_i = '0;
  logic [63:0] iop_i = '0;
  logic        valid_o;
  logic [63:0] res_o;
  logic        wr_en_o;
  logic        inv_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic        inv;
    string       tag;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;

  fpm_unit u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .fmt_i(fmt_i),
    .src_i(src_i), .cc_i(cc_i), .cc_sel_i(cc_sel_i), .iop_i(iop_i),
    .valid_o(valid_o), .res_o(res_o), .wr_en_o(wr_en_o), .inv_o(inv_o)
  );

  function automatic item_t model(logic [2:0] op, logic fmt, logic [63:0] src,
                                  logic [7:0] cc, logic [2:0] sel,
                                  logic [63:0] iop, string tag);
    item_t it;
    logic take, snan;
    logic [63:0] v;
    int sp;
    case (op)
      3'd0, 3'd5, 3'd6: take = 1'b1;
      3'd1: take = cc[sel];
      3'd2: take = !cc[sel];
      3'd3: take = (iop == 64'd0);
      3'd4: take = (iop != 64'd0);
      default: take = 1'b0;
    endcase
    v  = fmt ? src : {32'd0, src[31:0]};
    sp = fmt ? 63 : 31;
    if (op == 3'd5) v[sp] = 1'b0;
    if (op == 3'd6) v[sp] = ~v[sp];
    if (fmt) snan = (src[62:52] == 11'h7ff) && (src[51:0] != 0) && !src[51];
    else     snan = (src[30:23] == 8'hff) && (src[22:0] != 0) && !src[22];
    it.res = take ? v : 64'd0;
    it.we  = take;
    it.inv = take && (op == 3'd5 || op == 3'd6) && snan;
    it.tag = tag;
    return it;
  endfunction

  task automatic drive(logic [2:0] op, logic fmt, logic [63:0] src,
                       logic [7:0] cc, logic [2:0] sel, logic [63:0] iop,
                       string tag);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; fmt_i = fmt; src_i = src;
    cc_i = cc; cc_sel_i = sel; iop_i = iop;
    sb.push_back(model(op, fmt, src, cc, sel, iop, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      src_i = 64'hdead_beef_0bad_f00d;
      op_i = 3'd6;
    end
  endtask

  // monitor: compare at the falling edge, after the registers have settled
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected result actual res=%h exp none", res_o);
      end else begin
        item_t e;
        e = sb.pop_front();
        if (res_o !== e.res || wr_en_o !== e.we || inv_o !== e.inv) begin
          n_bad++;
          $display("FAIL %s: actual res=%h we=%b inv=%b expected res=%h we=%b inv=%b",
                   e.tag, res_o, wr_en_o, inv_o, e.res, e.we, e.inv);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (valid_o !== 1'b0 || res_o !== 64'd0 || wr_en_o !== 1'b0 || inv_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: actual v=%b res=%h we=%b inv=%b expected all zero",
               valid_o, res_o, wr_en_o, inv_o);
    end
    rst = 1'b0;
    idle(1);

    // R3 plain moves
    drive(3'd0, 1'b1, 64'hc00f_1234_5678_9abc, 8'h00, 3'd0, 64'd0, "R3");
    drive(3'd0, 1'b1, 64'h7ff4_0000_0000_0001, 8'h00, 3'd0, 64'd0, "R3");
    drive(3'd0, 1'b0, 64'hffff_ffff_bf80_0000, 8'h00, 3'd0, 64'd0, "R3_R9");
    // R4 condition-code moves
    drive(3'd1, 1'b1, 64'h4000_0000_0000_0000, 8'b0010_0000, 3'd5, 64'd0, "R4");
    drive(3'd1, 1'b1, 64'h4000_0000_0000_0000, 8'b1101_1111, 3'd5, 64'd0, "R4_R6");
    drive(3'd2, 1'b0, 64'h0000_0000_3f80_0000, 8'b0111_1111, 3'd7, 64'd0, "R4");
    drive(3'd2, 1'b0, 64'h0000_0000_3f80_0000, 8'b0000_0001, 3'd0, 64'd0, "R4_R6");
    // R5 integer zero-test moves, across the full width
    drive(3'd3, 1'b1, 64'h1234_5678_9abc_def0, 8'h00, 3'd0, 64'd0, "R5");
    drive(3'd3, 1'b1, 64'h1234_5678_9abc_def0, 8'h00, 3'd0, 64'h8000_0000_0000_0000, "R5_R6");
    drive(3'd4, 1'b0, 64'h0000_0000_c120_0000, 8'h00, 3'd0, 64'h8000_0000_0000_0000, "R5");
    drive(3'd4, 1'b0, 64'h0000_0000_c120_0000, 8'hff, 3'd0, 64'd0, "R5_R6");
    idle(2);
    // R7 sign operations
    drive(3'd5, 1'b1, 64'hc008_0000_0000_0000, 8'h00, 3'd0, 64'd0, "R7");
    drive(3'd6, 1'b1, 64'h4008_0000_0000_0000, 8'h00, 3'd0, 64'd0, "R7");
    drive(3'd6, 1'b0, 64'h0000_0000_bf80_0000, 8'h00, 3'd0, 64'd0, "R7");
    drive(3'd5, 1'b0, 64'h0000_0000_bf80_0000, 8'h00, 3'd0, 64'd0, "R7");
    // R8 NaN classification
    drive(3'd5, 1'b1, 64'hfff4_0000_0000_0000, 8'h00, 3'd0, 64'd0, "R8");
    drive(3'd6, 1'b1, 64'h7ff8_0000_0000_0001, 8'h00, 3'd0, 64'd0, "R8");
    drive(3'd6, 1'b1, 64'h7ff0_0000_0000_0000, 8'h00, 3'd0, 64'd0, "R8");
    drive(3'd6, 1'b0, 64'h0000_0000_7f80_0001, 8'h00, 3'd0, 64'd0, "R8");
    drive(3'd5, 1'b0, 64'h0000_0000_ffc0_0001, 8'h00, 3'd0, 64'd0, "R8");
    // R9 single ignores a NaN that sits only in the upper half
    drive(3'd5, 1'b0, 64'h7ff4_0000_4040_0000, 8'h00, 3'd0, 64'd0, "R9");
    // R10 reserved opcode
    drive(3'd7, 1'b1, 64'h7ff4_0000_0000_0000, 8'hff, 3'd0, 64'd0, "R10");
    idle(3);

    // R2: every expected result must have been delivered
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R2: actual %0d results pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule